// File: doc/BRIEF.md
# Programmable Clock-Output Divider

The block turns the system clock into a slower square wave on an output pin. A prescaler divides the system clock by 1, 2, 4 or 8 and produces a one-cycle enable. An 8-bit counter advances on each enable and is compared against a programmable limit. Each time the counter reaches the limit it restarts, the output toggles, and a one-cycle interrupt pulse is raised. A limit of zero is treated as 256, which gives the longest half period.

Software programs the block through two write strobes. One strobe loads the limit. The other loads the prescaler choice and an output-disable bit. While the disable bit is set, the pin is held low, but the divider and the interrupt keep running. When the bit is cleared again, the output resumes in step with the divider. The whole block runs on the single system clock; the divided clock is only a registered data signal.

Top module: `clkout_div`

## Requirements
- R1: After reset, clk_o and irq_o are 0. The limit is 0, the prescaler divides by 1 and output disable is 1. The counter holds 1 and the prescaler phase is 0.
- R2: psel_i encodes the prescaler ratio: 0 gives /1, 1 gives /2, 2 gives /4 and 3 gives /8. After a restart, the first counter tick falls on the D-th system clock, where D is the ratio, and later ticks follow every D clocks.
- R3: With a limit N from 1 to 255, a match occurs on every N-th counter tick, so the output period is 2×N ticks.
- R4: With a limit of 0, the counter runs from 1 up through 255 and wraps to 0. The match occurs at 0, so a half period lasts 256 ticks.
- R5: Each match produces a single-cycle high on irq_o in the same cycle that the output level toggles.
- R6: While output disable is 1, clk_o is 0. irq_o keeps pulsing and the toggle state keeps running, so when disable is cleared the output shows the same phase it would have had without the disable.
- R7: A write on the limit strobe restarts both the counter (to 1) and the prescaler phase. No match occurs in the cycle of the write, and the toggle state is kept.
- R8: A write on the control strobe restarts the counter and prescaler only if the prescaler choice changes. A write that keeps the same choice leaves the counting unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_we_i | input | 1 | Write strobe for the limit |
| cmp_i | input | 8 | New limit value |
| ctl_we_i | input | 1 | Write strobe for the control fields |
| psel_i | input | 2 | Prescaler select (0:/1, 1:/2, 2:/4, 3:/8) |
| odis_i | input | 1 | Output disable (1 forces clk_o low) |
| clk_o | output | 1 | Divided clock output |
| irq_o | output | 1 | One-cycle pulse on every match |

## Verification
The hardest cases to reach involve timing. One is a write that lands partway through a half period, where the restart must win over a match due in the same cycle. The other is a disable window that spans several toggles. The stimulus places limit writes a few cycles into a running half period, including a rewrite of the same value. It changes the prescaler in the middle of a count, and it holds the disable bit across more than one match before releasing it. A behavioural model counts the ticks and predicts the pin and the interrupt on every clock.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int CNT_W = 8;
  localparam int PS_W  = 3;
  typedef enum logic [1:0] {PS_DIV1 = 2'd0, PS_DIV2 = 2'd1, PS_DIV4 = 2'd2, PS_DIV8 = 2'd3} psel_e;
endpackage

// File: rtl/clkout_presc.sv
module clkout_presc
  import clkout_pkg::*;
#(
  parameter int W = PS_W
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  restart_i,
  input  psel_e psel_i,
  output logic  tick_o
);
  logic [W-1:0] phase_q;
  logic [W-1:0] mask;

  always_comb begin
    for (int i = 0; i < W; i++) mask[i] = (i < int'(psel_i));
  end

  assign tick_o = ((phase_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= '0;
    else if (restart_i) phase_q <= '0;
    else                phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/clkout_cnt.sv
module clkout_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         tick_i,
  input  logic [W-1:0] cmp_i,
  output logic         match_o,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] START = W'(1);
  logic [W-1:0] cnt_q;

  // restart wins over a coinciding match
  assign match_o = tick_i & ~restart_i & (cnt_q == cmp_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= START;
    else if (restart_i) cnt_q <= START;
    else if (tick_i)    cnt_q <= match_o ? START : cnt_q + 1'b1;
  end
endmodule

// File: rtl/clkout_div.sv
module clkout_div
  import clkout_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             ctl_we_i,
  input  logic [1:0]       psel_i,
  input  logic             odis_i,
  output logic             clk_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cmp_q;
  psel_e            psel_q;
  logic             odis_q, tgl_q, irq_q;
  logic             restart, tick_w, match_w;
  logic [CNT_W-1:0] cnt_w;

  assign restart = cmp_we_i | (ctl_we_i & (psel_i != psel_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      psel_q <= PS_DIV1;
      odis_q <= 1'b1;
    end else begin
      if (cmp_we_i) cmp_q <= cmp_i;
      if (ctl_we_i) begin
        psel_q <= psel_e'(psel_i);
        odis_q <= odis_i;
      end
    end
  end

  clkout_presc #(.W(PS_W)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .psel_i    (psel_q),
    .tick_o    (tick_w)
  );

  clkout_cnt #(.W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_i    (tick_w),
    .cmp_i     (cmp_q),
    .match_o   (match_w),
    .cnt_o     (cnt_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      tgl_q <= tgl_q ^ match_w;
      irq_q <= match_w;
    end
  end

  assign clk_o = tgl_q & ~odis_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/clkout_div_chk.sv
module clkout_div_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmp_we_i,
  input logic       odis_q,
  input logic       tgl_q,
  input logic       clk_o,
  input logic       irq_o,
  input logic [7:0] cnt_w,
  input logic [7:0] cmp_q,
  input logic [1:0] psel_q,
  input logic       tick_w
);
  // R6
  odis_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) odis_q |-> !clk_o);
  // R5
  irq_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_o |-> (tgl_q != $past(tgl_q)));
  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cmp_we_i |=> (cnt_w == 8'd1) && !irq_o);
  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (cmp_q != 8'd0) |-> (cnt_w != 8'd0) && (cnt_w <= cmp_q));
  // R2
  div1_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (psel_q == 2'd0) |-> tick_w);
endmodule

bind clkout_div clkout_div_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cmp_we_i (cmp_we_i),
  .odis_q   (odis_q),
  .tgl_q    (tgl_q),
  .clk_o    (clk_o),
  .irq_o    (irq_o),
  .cnt_w    (cnt_w),
  .cmp_q    (cmp_q),
  .psel_q   (psel_q),
  .tick_w   (tick_w)
);

// File: tb/clkout_div_tb_top.sv
module clkout_div_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cmp_we = 1'b0, ctl_we = 1'b0, odis = 1'b1;
  logic [7:0] cmp_d = '0;
  logic [1:0] psel_d = '0;
  logic       clk_o, irq_o;

  int    n_vec = 0, n_err = 0, cycles = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_cmp = 0, m_psel = 0, m_odis = 1, m_k = 0, m_t = 0;
  bit m_tgl = 0, m_irq = 0;

  clkout_div dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmp_we_i(cmp_we), .cmp_i(cmp_d),
    .ctl_we_i(ctl_we), .psel_i(psel_d), .odis_i(odis), .clk_o(clk_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmp = 0; m_psel = 0; m_odis = 1; m_k = 0; m_t = 0; m_tgl = 0; m_irq = 0;
    end else begin
      int  div, half;
      bit  rs, tk, mt;
      div  = 1 << m_psel;
      half = (m_cmp == 0) ? 256 : m_cmp;
      rs   = cmp_we || (ctl_we && (int'(psel_d) != m_psel));
      tk   = ((m_k % div) == div - 1);
      mt   = 0;
      if (rs) begin
        m_k = 0; m_t = 0;
      end else begin
        if (tk) begin
          m_t++;
          if (m_t == half) begin mt = 1; m_t = 0; end
        end
        m_k++;
      end
      if (cmp_we) m_cmp = cmp_d;
      if (ctl_we) begin m_psel = psel_d; m_odis = odis; end
      m_irq = mt;
      m_tgl = m_tgl ^ mt;
    end
  end

  always @(negedge clk) begin
    bit e_clk;
    cycles++;
    if (!done) begin
      e_clk = m_tgl && (m_odis == 0);
      n_vec++;
      if (clk_o !== e_clk || irq_o !== m_irq) begin
        n_err++;
        $display("FAIL %s cycle %0d: clk_o=%b irq_o=%b expected clk_o=%b irq_o=%b",
                 cur_req, cycles, clk_o, irq_o, e_clk, m_irq);
      end
      if (cycles > WATCHDOG) begin
        n_err++;
        $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_cmp(input int v);
    @(negedge clk); cmp_we = 1; cmp_d = 8'(v);
    @(negedge clk); cmp_we = 0;
  endtask

  task automatic wr_ctl(input int ps, input bit dis);
    @(negedge clk); ctl_we = 1; psel_d = 2'(ps); odis = dis;
    @(negedge clk); ctl_we = 0;
  endtask

  initial begin
    cur_req = "R1";          // reset state
    idle(4);
    rst_n = 1;
    idle(3);
    cur_req = "R3";          // N=3 at /1
    wr_ctl(0, 0);
    wr_cmp(3); idle(40);
    wr_cmp(1); idle(12);     // N=1 toggles every tick
    cur_req = "R4";          // limit 0 -> 256 ticks
    wr_cmp(0); idle(1100);
    cur_req = "R2";          // prescaler ratios
    wr_cmp(2); wr_ctl(2, 0); idle(60);
    wr_ctl(3, 0); idle(100);
    wr_ctl(1, 0); idle(40);
    cur_req = "R6";          // disable across several matches, same psel
    wr_ctl(1, 1); idle(45);
    wr_ctl(1, 0); idle(30);
    cur_req = "R8";          // same psel write keeps phase, changed psel restarts
    wr_cmp(7); idle(9);
    wr_ctl(1, 0); idle(11);
    wr_ctl(2, 0); idle(70);
    cur_req = "R7";          // mid-period limit writes
    wr_ctl(0, 0);
    wr_cmp(5); idle(3);
    wr_cmp(5); idle(4);
    wr_cmp(4); idle(30);
    cur_req = "R5";          // interrupt pulses at every match
    wr_cmp(2); idle(30);
    finish_run();
  end
endmodule